// File: doc/BRIEF.md
# Bit-Manipulation Execute Unit

This block is the single-cycle execute stage for the non-counting half of a 32-bit bit-manipulation instruction group. It takes the full instruction word together with two source operand values, and in the same cycle it returns a 32-bit result and a flag. The flag is raised when the word is not one of the supported encodings. It works out the operation from the major opcode, the funct3 and funct7 fields and, where the encoding requires it, the rs2 field. It then steers the operands through one of three datapaths: compare and negated logic, permutation (rotates, byte spread, byte swap, extension), or scaled address add.

The surrounding pipeline supplies operands that have already been read from the register file. It writes the result back only when the flag is low. The register specifier fields rd and rs1 carry no meaning for this unit. Two build-time switches remove the min/max hardware or the scaled-add hardware. Encodings that belong to a removed group are then reported as unrecognised.

Top module: `bmu_exec`

## Requirements
- R1: With major opcode 0110011 and funct7 0000101, funct3 100 returns the two's-complement smaller operand, 101 the unsigned smaller, 110 the two's-complement larger and 111 the unsigned larger.
- R2: With major opcode 0110011 and funct7 0100000, the second operand is bit-inverted and then combined with the first operand: funct3 111 gives AND, 110 gives OR, 100 gives XOR.
- R3: With major opcode 0110011 and funct7 0110000, funct3 001 rotates the first operand left and funct3 101 rotates it right. The amount is operand B bits 4:0 only, and an amount of zero returns the first operand unchanged.
- R4: With major opcode 0010011, funct7 0110000 and funct3 101, the first operand is rotated right by the 5-bit value in instruction bits 24:20.
- R5: With major opcode 0010011, funct7 0010100, funct3 101 and bits 24:20 equal to 00111, each result byte is 0xFF when the same byte of the first operand is non-zero and 0x00 when it is zero.
- R6: With major opcode 0010011, funct7 0110100, funct3 101 and bits 24:20 equal to 11000, the byte order is reversed: operand byte 0 goes to result byte 3, byte 1 to 2, byte 2 to 1 and byte 3 to 0.
- R7: With major opcode 0010011, funct7 0110000 and funct3 001, bits 24:20 equal to 00100 copy operand bit 7 into bits 31:8, and 00101 copies bit 15 into bits 31:16.
- R8: With major opcode 0110011, funct7 0000100, funct3 100 and bits 24:20 equal to 00000, the result keeps operand bits 15:0 and clears bits 31:16.
- R9: With major opcode 0110011 and funct7 0010000, funct3 010, 100 and 110 return operand B plus operand A shifted left by 1, 2 or 3, modulo 2^32.
- R10: Any word that matches none of the encodings above raises `illegal_o` and forces `result_o` to zero. Every matching word keeps `illegal_o` low.
- R11: Instruction bits 19:15 and 11:7 have no effect on either output.
- R12: When HAS_MINMAX is 0 the R1 encodings are unrecognised, and when HAS_SHADD is 0 the R9 encodings are unrecognised. The other operations behave as with the defaults.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word to decode |
| op_a_i | input | 32 | First source operand value |
| op_b_i | input | 32 | Second source operand value |
| result_o | output | 32 | Operation result, zero when unrecognised |
| illegal_o | output | 1 | High when the instruction word is not a supported encoding |

## Verification
The bench instantiates two copies of the unit side by side. The first uses the default switches, with both optional groups present, and covers every encoding, the rotate amounts 0, 31 and values above 31, signed and unsigned comparisons across the sign boundary, and scaled adds that wrap. The second is built with HAS_MINMAX and HAS_SHADD both at 0. This makes the removal of a group observable: the same min/max and scaled-add words must read back as unrecognised with a zero result, while a negated-logic word on the reduced copy still computes correctly.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

  localparam int XLEN    = 32;
  localparam int SHAMT_W = $clog2(XLEN);

  localparam logic [6:0] OPC_REG = 7'b0110011;
  localparam logic [6:0] OPC_IMM = 7'b0010011;

  localparam logic [6:0] F7_MINMAX = 7'b0000101;
  localparam logic [6:0] F7_NEGLOG = 7'b0100000;
  localparam logic [6:0] F7_ROTEXT = 7'b0110000;
  localparam logic [6:0] F7_ZEXT   = 7'b0000100;
  localparam logic [6:0] F7_SHADD  = 7'b0010000;
  localparam logic [6:0] F7_ORCMB  = 7'b0010100;
  localparam logic [6:0] F7_BSWAP  = 7'b0110100;

  typedef enum logic [4:0] {
    OP_NONE, OP_MIN, OP_MINU, OP_MAX, OP_MAXU,
    OP_ANDN, OP_ORN, OP_XNOR,
    OP_ROL, OP_ROR, OP_RORI,
    OP_ORCB, OP_REV8, OP_SEXTB, OP_SEXTH, OP_ZEXTH,
    OP_SH1ADD, OP_SH2ADD, OP_SH3ADD
  } bmu_op_e;

  typedef struct packed {
    logic [6:0] funct7;
    logic [4:0] rs2;
    logic [2:0] funct3;
    logic [6:0] opcode;
  } bmu_fields_t;

endpackage

// File: rtl/bmu_decode.sv
module bmu_decode
  import bmu_pkg::*;
#(
  parameter bit HAS_MINMAX = 1'b1,
  parameter bit HAS_SHADD  = 1'b1
) (
  input  bmu_fields_t fields_i,
  output bmu_op_e     op_o,
  output logic        illegal_o
);

  bmu_op_e op_raw;

  always_comb begin
    op_raw = OP_NONE;
    if (fields_i.opcode == OPC_REG) begin
      case (fields_i.funct7)
        F7_MINMAX: begin
          case (fields_i.funct3)
            3'b100:  op_raw = OP_MIN;
            3'b101:  op_raw = OP_MINU;
            3'b110:  op_raw = OP_MAX;
            3'b111:  op_raw = OP_MAXU;
            default: op_raw = OP_NONE;
          endcase
        end
        F7_NEGLOG: begin
          case (fields_i.funct3)
            3'b111:  op_raw = OP_ANDN;
            3'b110:  op_raw = OP_ORN;
            3'b100:  op_raw = OP_XNOR;
            default: op_raw = OP_NONE;
          endcase
        end
        F7_ROTEXT: begin
          case (fields_i.funct3)
            3'b001:  op_raw = OP_ROL;
            3'b101:  op_raw = OP_ROR;
            default: op_raw = OP_NONE;
          endcase
        end
        F7_ZEXT: begin
          if (fields_i.funct3 == 3'b100 && fields_i.rs2 == 5'b00000)
            op_raw = OP_ZEXTH;
        end
        F7_SHADD: begin
          case (fields_i.funct3)
            3'b010:  op_raw = OP_SH1ADD;
            3'b100:  op_raw = OP_SH2ADD;
            3'b110:  op_raw = OP_SH3ADD;
            default: op_raw = OP_NONE;
          endcase
        end
        default: op_raw = OP_NONE;
      endcase
    end else if (fields_i.opcode == OPC_IMM) begin
      case (fields_i.funct7)
        F7_ROTEXT: begin
          if (fields_i.funct3 == 3'b101)
            op_raw = OP_RORI;
          else if (fields_i.funct3 == 3'b001 && fields_i.rs2 == 5'b00100)
            op_raw = OP_SEXTB;
          else if (fields_i.funct3 == 3'b001 && fields_i.rs2 == 5'b00101)
            op_raw = OP_SEXTH;
        end
        F7_ORCMB: begin
          if (fields_i.funct3 == 3'b101 && fields_i.rs2 == 5'b00111)
            op_raw = OP_ORCB;
        end
        F7_BSWAP: begin
          if (fields_i.funct3 == 3'b101 && fields_i.rs2 == 5'b11000)
            op_raw = OP_REV8;
        end
        default: op_raw = OP_NONE;
      endcase
    end
  end

  always_comb begin
    op_o = op_raw;
    if (!HAS_MINMAX && (op_raw inside {OP_MIN, OP_MINU, OP_MAX, OP_MAXU}))
      op_o = OP_NONE;
    if (!HAS_SHADD && (op_raw inside {OP_SH1ADD, OP_SH2ADD, OP_SH3ADD}))
      op_o = OP_NONE;
  end

  assign illegal_o = (op_o == OP_NONE);

endmodule

// File: rtl/bmu_cmp_logic.sv
module bmu_cmp_logic
  import bmu_pkg::*;
#(
  parameter int W          = 32,
  parameter bit HAS_MINMAX = 1'b1
) (
  input  bmu_op_e        op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [W-1:0]   y_o
);

  logic [W-1:0] b_inv;
  logic [W-1:0] sel_y;
  logic [W-1:0] neg_y;

  assign b_inv = ~b_i;

  generate
    if (HAS_MINMAX) begin : g_minmax
      logic a_lt_s;
      logic a_lt_u;
      assign a_lt_s = ($signed(a_i) < $signed(b_i));
      assign a_lt_u = (a_i < b_i);
      always_comb begin
        case (op_i)
          OP_MIN:  sel_y = a_lt_s ? a_i : b_i;
          OP_MINU: sel_y = a_lt_u ? a_i : b_i;
          OP_MAX:  sel_y = a_lt_s ? b_i : a_i;
          OP_MAXU: sel_y = a_lt_u ? b_i : a_i;
          default: sel_y = '0;
        endcase
      end
    end else begin : g_no_minmax
      assign sel_y = '0;
    end
  endgenerate

  always_comb begin
    case (op_i)
      OP_ANDN: neg_y = a_i & b_inv;
      OP_ORN:  neg_y = a_i | b_inv;
      OP_XNOR: neg_y = a_i ^ b_inv;
      default: neg_y = '0;
    endcase
  end

  assign y_o = sel_y | neg_y;

endmodule

// File: rtl/bmu_permute.sv
module bmu_permute
  import bmu_pkg::*;
#(
  parameter int W = 32
) (
  input  bmu_op_e                  op_i,
  input  logic [W-1:0]             a_i,
  input  logic [$clog2(W)-1:0]     amt_i,
  output logic [W-1:0]             y_o
);

  localparam int NBYTE = W / 8;

  logic [2*W-1:0] dbl;
  logic [2*W-1:0] dbl_l;
  logic [2*W-1:0] dbl_r;
  logic [W-1:0]   orc_y;
  logic [W-1:0]   rev_y;

  // Rotating a doubled copy keeps every shift below 2*W and makes amount 0 trivial.
  assign dbl   = {a_i, a_i};
  assign dbl_l = dbl << amt_i;
  assign dbl_r = dbl >> amt_i;

  generate
    for (genvar k = 0; k < NBYTE; k++) begin : g_byte
      assign orc_y[8*k +: 8] = {8{|a_i[8*k +: 8]}};
      assign rev_y[8*k +: 8] = a_i[8*(NBYTE-1-k) +: 8];
    end
  endgenerate

  always_comb begin
    case (op_i)
      OP_ROL:            y_o = dbl_l[2*W-1:W];
      OP_ROR, OP_RORI:   y_o = dbl_r[W-1:0];
      OP_ORCB:           y_o = orc_y;
      OP_REV8:           y_o = rev_y;
      OP_SEXTB:          y_o = {{(W-8){a_i[7]}}, a_i[7:0]};
      OP_SEXTH:          y_o = {{(W-16){a_i[15]}}, a_i[15:0]};
      OP_ZEXTH:          y_o = {{(W-16){1'b0}}, a_i[15:0]};
      default:           y_o = '0;
    endcase
  end

endmodule

// File: rtl/bmu_shadd.sv
module bmu_shadd
  import bmu_pkg::*;
#(
  parameter int W = 32
) (
  input  bmu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);

  logic [W-1:0] a_scaled;
  logic         hit;

  always_comb begin
    hit = 1'b1;
    case (op_i)
      OP_SH1ADD: a_scaled = {a_i[W-2:0], 1'b0};
      OP_SH2ADD: a_scaled = {a_i[W-3:0], 2'b00};
      OP_SH3ADD: a_scaled = {a_i[W-4:0], 3'b000};
      default: begin
        a_scaled = '0;
        hit      = 1'b0;
      end
    endcase
  end

  assign y_o = hit ? (b_i + a_scaled) : '0;

endmodule

// File: rtl/bmu_exec.sv
module bmu_exec
  import bmu_pkg::*;
#(
  parameter bit HAS_MINMAX = 1'b1,
  parameter bit HAS_SHADD  = 1'b1
) (
  input  logic [31:0] instr_i,
  input  logic [31:0] op_a_i,
  input  logic [31:0] op_b_i,
  output logic [31:0] result_o,
  output logic        illegal_o
);

  bmu_fields_t         fields;
  bmu_op_e             op;
  logic [SHAMT_W-1:0]  rot_amt;
  logic [XLEN-1:0]     y_cmp;
  logic [XLEN-1:0]     y_perm;
  logic [XLEN-1:0]     y_add;
  logic [9:0]          unused_regspec;

  assign fields         = {instr_i[31:20], instr_i[14:12], instr_i[6:0]};
  assign unused_regspec = {instr_i[19:15], instr_i[11:7]};

  bmu_decode #(
    .HAS_MINMAX (HAS_MINMAX),
    .HAS_SHADD  (HAS_SHADD)
  ) u_decode (
    .fields_i  (fields),
    .op_o      (op),
    .illegal_o (illegal_o)
  );

  assign rot_amt = (op == OP_RORI) ? fields.rs2[SHAMT_W-1:0] : op_b_i[SHAMT_W-1:0];

  bmu_cmp_logic #(
    .W          (XLEN),
    .HAS_MINMAX (HAS_MINMAX)
  ) u_cmp (
    .op_i (op),
    .a_i  (op_a_i),
    .b_i  (op_b_i),
    .y_o  (y_cmp)
  );

  bmu_permute #(
    .W (XLEN)
  ) u_perm (
    .op_i  (op),
    .a_i   (op_a_i),
    .amt_i (rot_amt),
    .y_o   (y_perm)
  );

  generate
    if (HAS_SHADD) begin : g_shadd
      bmu_shadd #(
        .W (XLEN)
      ) u_shadd (
        .op_i (op),
        .a_i  (op_a_i),
        .b_i  (op_b_i),
        .y_o  (y_add)
      );
    end else begin : g_no_shadd
      assign y_add = '0;
    end
  endgenerate

  // Each datapath drives zero for operations it does not own, so an OR merges them.
  assign result_o = y_cmp | y_perm | y_add;

endmodule

// File: rtl/bmu_exec_chk.sv
module bmu_exec_chk #(
  parameter bit HAS_MINMAX = 1'b1,
  parameter bit HAS_SHADD  = 1'b1
) (
  input logic [31:0] instr_i,
  input logic [31:0] op_a_i,
  input logic [31:0] op_b_i,
  input logic [31:0] result_o,
  input logic        illegal_o
);

  logic [6:0] c_opc;
  logic [6:0] c_f7;
  logic [2:0] c_f3;
  logic [4:0] c_rs2;
  logic       is_minmax;
  logic       is_orc;
  logic       is_rev;
  logic       is_zext;
  logic       is_rot;
  logic       is_shadd;

  assign c_opc = instr_i[6:0];
  assign c_f7  = instr_i[31:25];
  assign c_f3  = instr_i[14:12];
  assign c_rs2 = instr_i[24:20];

  assign is_minmax = (c_opc == 7'h33) && (c_f7 == 7'h05) && c_f3[2];
  assign is_orc    = (c_opc == 7'h13) && (c_f7 == 7'h14) && (c_f3 == 3'd5) && (c_rs2 == 5'd7);
  assign is_rev    = (c_opc == 7'h13) && (c_f7 == 7'h34) && (c_f3 == 3'd5) && (c_rs2 == 5'd24);
  assign is_zext   = (c_opc == 7'h33) && (c_f7 == 7'h04) && (c_f3 == 3'd4) && (c_rs2 == 5'd0);
  assign is_rot    = (c_f7 == 7'h30) && (c_f3 == 3'd5) && ((c_opc == 7'h33) || (c_opc == 7'h13));
  assign is_shadd  = (c_opc == 7'h33) && (c_f7 == 7'h10) && (c_f3 inside {3'd2, 3'd4, 3'd6});

  always_comb begin
    if (!$isunknown({instr_i, op_a_i, op_b_i})) begin
      AST_ILLEGAL_ZERO: assert (!illegal_o || result_o == 32'd0); // R10
      AST_MINMAX_PICKS_OPERAND: assert (!(is_minmax && !illegal_o) ||
                                        result_o == op_a_i || result_o == op_b_i); // R1
      AST_MINMAX_GATED: assert (HAS_MINMAX || !is_minmax || illegal_o); // R12
      AST_SHADD_GATED: assert (HAS_SHADD || !is_shadd || illegal_o); // R12
      AST_ROTATE_KEEPS_ONES: assert (!is_rot || illegal_o ||
                                     $countones(result_o) == $countones(op_a_i)); // R3
      AST_ZEXT_UPPER_CLEAR: assert (!is_zext || result_o[31:16] == 16'd0); // R8
      AST_REV_END_BYTES: assert (!is_rev || (result_o[7:0] == op_a_i[31:24] &&
                                              result_o[31:24] == op_a_i[7:0])); // R6
      for (int k = 0; k < 4; k++) begin
        AST_ORC_BYTE_FILL: assert (!is_orc ||
                                   result_o[8*k +: 8] == ((op_a_i[8*k +: 8] != 8'd0) ? 8'hFF : 8'h00)); // R5
      end
    end
  end

endmodule

bind bmu_exec bmu_exec_chk #(
  .HAS_MINMAX (HAS_MINMAX),
  .HAS_SHADD  (HAS_SHADD)
) u_bmu_exec_chk (
  .instr_i   (instr_i),
  .op_a_i    (op_a_i),
  .op_b_i    (op_b_i),
  .result_o  (result_o),
  .illegal_o (illegal_o)
);

// File: tb/bmu_exec_bench.sv
module bmu_exec_bench;

  logic        clk;
  logic        rst_n;
  logic [31:0] instr;
  logic [31:0] a;
  logic [31:0] b;
  logic [31:0] res_full;
  logic        ill_full;
  logic [31:0] res_lite;
  logic        ill_lite;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  bmu_exec u_bmu_exec (
    .instr_i (instr), .op_a_i (a), .op_b_i (b),
    .result_o (res_full), .illegal_o (ill_full)
  );

  bmu_exec #(.HAS_MINMAX(1'b0), .HAS_SHADD(1'b0)) u_bmu_exec_lite (
    .instr_i (instr), .op_a_i (a), .op_b_i (b),
    .result_o (res_lite), .illegal_o (ill_lite)
  );

  function automatic logic [31:0] enc(input logic [6:0] f7, input logic [4:0] rs2,
                                      input logic [2:0] f3, input logic [6:0] opc);
    return {f7, rs2, 5'd11, f3, 5'd12, opc};
  endfunction

  function automatic logic [31:0] m_rotl(input logic [31:0] v, input int n);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[(i + n) % 32] = v[i];
    return r;
  endfunction

  function automatic logic [31:0] m_rotr(input logic [31:0] v, input int n);
    return m_rotl(v, (32 - (n % 32)) % 32);
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] iw, input logic [31:0] va, input logic [31:0] vb);
    @(negedge clk);
    instr = iw; a = va; b = vb;
    #2;
  endtask

  task automatic expect_op(input string tag, input logic [31:0] iw, input logic [31:0] va,
                           input logic [31:0] vb, input logic [31:0] exp);
    apply(iw, va, vb);
    check(tag, res_full, exp);
    check({tag, " flag"}, {31'd0, ill_full}, 32'd0);
  endtask

  task automatic expect_illegal(input string tag, input logic [31:0] iw);
    apply(iw, 32'hDEADBEEF, 32'h12345678);
    check({tag, " flag"}, {31'd0, ill_full}, 32'd1);
    check({tag, " result"}, res_full, 32'd0);
  endtask

  task automatic t_reset;
    check("R10 reset-state flag", {31'd0, ill_full}, 32'd1);
    check("R10 reset-state result", res_full, 32'd0);
  endtask

  task automatic t_minmax;
    logic [31:0] pa[4] = '{32'h80000000, 32'h00000001, 32'hFFFFFFFF, 32'h7FFFFFFF};
    logic [31:0] pb[4] = '{32'h00000001, 32'h80000000, 32'h00000000, 32'h7FFFFFFF};
    for (int i = 0; i < 4; i++) begin
      logic [31:0] x = pa[i];
      logic [31:0] y = pb[i];
      expect_op("R1 min",  enc(7'h05, 5'd2, 3'b100, 7'h33), x, y, ($signed(x) < $signed(y)) ? x : y);
      expect_op("R1 minu", enc(7'h05, 5'd2, 3'b101, 7'h33), x, y, (x < y) ? x : y);
      expect_op("R1 max",  enc(7'h05, 5'd2, 3'b110, 7'h33), x, y, ($signed(x) < $signed(y)) ? y : x);
      expect_op("R1 maxu", enc(7'h05, 5'd2, 3'b111, 7'h33), x, y, (x < y) ? y : x);
    end
  endtask

  task automatic t_neglogic;
    logic [31:0] x = 32'hF0F0_A55A;
    logic [31:0] y = 32'h0FF0_3C3C;
    expect_op("R2 andn", enc(7'h20, 5'd2, 3'b111, 7'h33), x, y, x & ~y);
    expect_op("R2 orn",  enc(7'h20, 5'd2, 3'b110, 7'h33), x, y, x | ~y);
    expect_op("R2 xnor", enc(7'h20, 5'd2, 3'b100, 7'h33), x, y, ~(x ^ y));
  endtask

  task automatic t_rotreg;
    int amts[5] = '{0, 1, 13, 31, 35};
    logic [31:0] x = 32'h8000_00C3;
    for (int i = 0; i < 5; i++) begin
      expect_op("R3 rol", enc(7'h30, 5'd2, 3'b001, 7'h33), x, 32'hFFFF_FF00 | amts[i],
                m_rotl(x, amts[i] % 32));
      expect_op("R3 ror", enc(7'h30, 5'd2, 3'b101, 7'h33), x, 32'hFFFF_FF00 | amts[i],
                m_rotr(x, amts[i] % 32));
    end
    expect_op("R3 rol amount zero", enc(7'h30, 5'd2, 3'b001, 7'h33), x, 32'h0000_0020, x);
  endtask

  task automatic t_rotimm;
    logic [31:0] x = 32'h1234_5678;
    expect_op("R4 rori 20", enc(7'h30, 5'd20, 3'b101, 7'h13), x, 32'd3, m_rotr(x, 20));
    expect_op("R4 rori 0",  enc(7'h30, 5'd0,  3'b101, 7'h13), x, 32'd7, x);
    expect_op("R4 rori 31", enc(7'h30, 5'd31, 3'b101, 7'h13), x, 32'd0, m_rotr(x, 31));
  endtask

  task automatic t_bytes;
    expect_op("R5 orcb mixed", enc(7'h14, 5'd7, 3'b101, 7'h13), 32'h0080_0001, 0, 32'h00FF_00FF);
    expect_op("R5 orcb zero",  enc(7'h14, 5'd7, 3'b101, 7'h13), 32'h0000_0000, 0, 32'h0000_0000);
    expect_op("R5 orcb high",  enc(7'h14, 5'd7, 3'b101, 7'h13), 32'h1000_2000, 0, 32'hFF00_FF00);
    expect_op("R6 rev8", enc(7'h34, 5'd24, 3'b101, 7'h13), 32'h1122_3344, 0, 32'h4433_2211);
    expect_op("R6 rev8 b", enc(7'h34, 5'd24, 3'b101, 7'h13), 32'hA0B0_C0D0, 0, 32'hD0C0_B0A0);
  endtask

  task automatic t_extend;
    expect_op("R7 sextb neg", enc(7'h30, 5'd4, 3'b001, 7'h13), 32'h1234_5680, 0, 32'hFFFF_FF80);
    expect_op("R7 sextb pos", enc(7'h30, 5'd4, 3'b001, 7'h13), 32'hFFFF_FF7F, 0, 32'h0000_007F);
    expect_op("R7 sexth neg", enc(7'h30, 5'd5, 3'b001, 7'h13), 32'h0000_8001, 0, 32'hFFFF_8001);
    expect_op("R7 sexth pos", enc(7'h30, 5'd5, 3'b001, 7'h13), 32'hFFFF_7FFF, 0, 32'h0000_7FFF);
    expect_op("R8 zexth", enc(7'h04, 5'd0, 3'b100, 7'h33), 32'hABCD_9876, 0, 32'h0000_9876);
  endtask

  task automatic t_shadd;
    logic [31:0] x = 32'hE000_0003;
    logic [31:0] y = 32'hFFFF_FFF0;
    expect_op("R9 sh1add", enc(7'h10, 5'd2, 3'b010, 7'h33), x, y, y + x * 2);
    expect_op("R9 sh2add", enc(7'h10, 5'd2, 3'b100, 7'h33), x, y, y + x * 4);
    expect_op("R9 sh3add", enc(7'h10, 5'd2, 3'b110, 7'h33), x, y, y + x * 8);
  endtask

  task automatic t_illegal;
    expect_illegal("R10 count-style rs2", enc(7'h30, 5'd0, 3'b001, 7'h13));
    expect_illegal("R10 orcb wrong rs2",  enc(7'h14, 5'd8, 3'b101, 7'h13));
    expect_illegal("R10 zext wrong rs2",  enc(7'h04, 5'd1, 3'b100, 7'h33));
    expect_illegal("R10 unknown funct7",  enc(7'h01, 5'd2, 3'b100, 7'h33));
    expect_illegal("R10 unknown opcode",  enc(7'h05, 5'd2, 3'b100, 7'h3B));
    expect_illegal("R10 rev8 wrong f3",   enc(7'h34, 5'd24, 3'b001, 7'h13));
    expect_illegal("R10 shadd odd f3",    enc(7'h10, 5'd2, 3'b011, 7'h33));
  endtask

  task automatic t_regspec;
    logic [31:0] base = enc(7'h20, 5'd2, 3'b111, 7'h33);
    logic [31:0] x = 32'hCAFE_F00D;
    logic [31:0] y = 32'h0F0F_0F0F;
    for (int i = 0; i < 3; i++) begin
      logic [31:0] iw = base;
      iw[19:15] = 5'(7 * i + 1);
      iw[11:7]  = 5'(31 - 5 * i);
      expect_op("R11 regspec ignored", iw, x, y, x & ~y);
    end
  endtask

  task automatic t_lite;
    apply(enc(7'h05, 5'd2, 3'b100, 7'h33), 32'h5, 32'h9);
    check("R12 lite min flag", {31'd0, ill_lite}, 32'd1);
    check("R12 lite min result", res_lite, 32'd0);
    apply(enc(7'h10, 5'd2, 3'b100, 7'h33), 32'h5, 32'h9);
    check("R12 lite sh2add flag", {31'd0, ill_lite}, 32'd1);
    check("R12 lite sh2add result", res_lite, 32'd0);
    apply(enc(7'h20, 5'd2, 3'b111, 7'h33), 32'hFF00_FF00, 32'h0F0F_0F0F);
    check("R12 lite andn flag", {31'd0, ill_lite}, 32'd0);
    check("R12 lite andn result", res_lite, 32'hF000_F000);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    instr = 32'd0;
    a     = 32'd0;
    b     = 32'd0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    t_reset();
    t_minmax();
    t_neglogic();
    t_rotreg();
    t_rotimm();
    t_bytes();
    t_extend();
    t_shadd();
    t_illegal();
    t_regspec();
    t_lite();
    finish_run();
  end

endmodule